// File: doc/BRIEF.md
# EEPROM Write-and-Poll Sequencer

This block sits on the host side of a parallel byte-wide EEPROM. A client hands it one byte at a time over a valid/ready handshake. The sequencer drives the memory's chip-select, write-strobe and output-enable lines with setup, pulse, hold and recovery times counted in clock cycles. When the client marks a byte as the last one, the sequencer stops loading and checks whether the device has finished its internal programming cycle. It does this by polling, so it never has to wait out a fixed worst-case delay.

The last byte and its address are kept as the polling reference. Before each poll, the sequencer lets go of the bus for a set number of cycles. It then reads the reference address and compares bit 7 of the returned byte with bit 7 of the stored byte. A difference means the device is still programming, and another wait-and-poll round follows. Equal bits end the operation with a one-cycle done pulse. If the poll count reaches a limit derived from the 10 ms worst-case programming time, a one-cycle timeout pulse ends the operation instead.

Several bytes marked not-last are loaded back to back as one page, and polling starts only after the final byte of the page. All timing values are parameters given in nanoseconds and converted to whole clock cycles, rounded up, with a minimum of one.

Top module: `eeprom_poll_writer`

## Requirements
- R1: After reset, req_ready is 1, mem_cs_n, mem_we_n and mem_oe_n are 1, mem_dq_oe is 0, and done and timeout are 0.
- R2: A byte is accepted in a cycle where req_valid and req_ready are both 1. req_ready is 0 in the cycle after acceptance.
- R3: Each write strobe keeps mem_we_n low for at least ceil(WP_NS/CLK_NS) cycles, which is 38 at the defaults. Throughout the strobe, mem_dq_oe is 1 and mem_dout holds steady.
- R4: Between the end of one strobe and the start of the next, mem_we_n stays high for at least ceil(WPH_NS/CLK_NS) cycles, which is 13 at the defaults.
- R5: mem_oe_n is never low while mem_we_n is low, and mem_dq_oe is 0 whenever mem_oe_n is low.
- R6: Before every poll read, mem_cs_n stays high for at least YIELD_CYC cycles, with the data bus not driven.
- R7: Each poll holds mem_cs_n and mem_oe_n low together. During that time, mem_addr equals the address of the last byte written.
- R8: A poll whose mem_din[7] differs from bit 7 of the last byte written starts another round. A poll whose bit 7 matches ends the operation with done high for exactly one cycle, followed by req_ready.
- R9: The poll limit is WC_NS/(CLK_NS*(YIELD_CYC+ceil(ACC_NS/CLK_NS)))+1. If every poll up to that limit mismatches, timeout pulses for one cycle, done stays 0, and req_ready returns.
- R10: A byte accepted with req_last=0 is written, and req_ready returns without any poll. Polling starts only after a byte with req_last=1, and it uses that final byte as its reference.
- R11: The byte on mem_dout and the address on mem_addr at the rising edge of the write strobe are exactly the requested byte and address.
- R12: done and timeout are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Client offers a byte |
| req_ready | output | 1 | Sequencer can take a byte |
| req_addr | input | AW | Byte address |
| req_data | input | 8 | Byte to write |
| req_last | input | 1 | Byte ends the page; polling follows |
| done | output | 1 | One-cycle pulse: programming confirmed |
| timeout | output | 1 | One-cycle pulse: poll limit reached |
| mem_addr | output | AW | Memory address bus |
| mem_dout | output | 8 | Data driven toward the memory |
| mem_dq_oe | output | 1 | Host drives the data bus when 1 |
| mem_din | input | 8 | Data read from the memory |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low |

## Verification
The assertions check the bus rules on every cycle:
- the strobe width and strobe-to-strobe recovery, measured with counters;
- a stable driven byte under the strobe;
- output-enable never overlapping the strobe or host drive;
- the released-bus gap before each read;
- the poll address matching the last strobed address;
- done and timeout being exclusive single-cycle pulses.

Only the bench scenarios, run against a memory model with a programmable busy time, can show the rest:
- the bit-7 decision is correct, meaning every poll before done saw a busy device and the last one did not;
- an immediately ready device finishes after exactly one poll;
- a device that never finishes ends in a timeout after exactly the computed poll count;
- page bytes reach their own addresses while polling references only the final byte.

// File: rtl/eeprom_poll_writer.sv
module eeprom_poll_writer #(
  parameter int AW        = 15,
  parameter int CLK_NS    = 4,
  parameter int AS_NS     = 10,
  parameter int WP_NS     = 150,
  parameter int WPH_NS    = 50,
  parameter int DH_NS     = 10,
  parameter int ACC_NS    = 150,
  parameter int YIELD_CYC = 64,
  parameter int WC_NS     = 10_000_000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic [7:0]    req_data,
  input  logic          req_last,
  output logic          done,
  output logic          timeout,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_dout,
  output logic          mem_dq_oe,
  input  logic [7:0]    mem_din,
  output logic          mem_cs_n,
  output logic          mem_we_n,
  output logic          mem_oe_n
);

  function automatic int cyc(input int ns);
    int c;
    c = (ns + CLK_NS - 1) / CLK_NS;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int SETUP_C   = cyc(AS_NS);
  localparam int PULSE_C   = cyc(WP_NS);
  localparam int HOLD_C    = cyc(DH_NS);
  localparam int HIGH_C    = cyc(WPH_NS);
  localparam int READ_C    = cyc(ACC_NS);
  localparam int YIELD_C   = (YIELD_CYC < 1) ? 1 : YIELD_CYC;
  localparam int POLL_C    = YIELD_C + READ_C;
  localparam int MAX_POLLS = WC_NS / (CLK_NS * POLL_C) + 1;
  localparam int CNT_MAX   = max2(max2(max2(SETUP_C, PULSE_C), max2(HOLD_C, HIGH_C)),
                                  max2(READ_C, YIELD_C));
  localparam int CW        = $clog2(CNT_MAX + 1);
  localparam int PW        = $clog2(MAX_POLLS + 1);

  typedef enum logic [2:0] {
    S_IDLE, S_SETUP, S_STROBE, S_HOLD, S_GAP, S_PAGE, S_YIELD, S_READ
  } st_t;

  st_t           st, st_n;
  logic [CW-1:0] cnt, lim;
  logic [PW-1:0] polls;
  logic [AW-1:0] addr_q;
  logic [7:0]    data_q;
  logic          last_q;
  logic          at_end, match, last_poll, take;

  assign take      = req_valid && req_ready;
  assign at_end    = (cnt == lim);
  assign match     = (mem_din[7] == data_q[7]);
  assign last_poll = (polls == PW'(MAX_POLLS - 1));
  assign mem_addr  = addr_q;
  assign mem_dout  = data_q;

  always_comb begin
    case (st)
      S_SETUP:  lim = CW'(SETUP_C - 1);
      S_STROBE: lim = CW'(PULSE_C - 1);
      S_HOLD:   lim = CW'(HOLD_C - 1);
      S_GAP:    lim = CW'(HIGH_C - 1);
      S_YIELD:  lim = CW'(YIELD_C - 1);
      S_READ:   lim = CW'(READ_C - 1);
      default:  lim = '0;
    endcase
  end

  always_comb begin
    st_n = st;
    case (st)
      S_IDLE, S_PAGE: if (req_valid) st_n = S_SETUP;
      S_SETUP:  if (at_end) st_n = S_STROBE;
      S_STROBE: if (at_end) st_n = S_HOLD;
      S_HOLD:   if (at_end) st_n = last_q ? S_YIELD : S_GAP;
      S_GAP:    if (at_end) st_n = S_PAGE;
      S_YIELD:  if (at_end) st_n = S_READ;
      S_READ:   if (at_end) st_n = (match || last_poll) ? S_IDLE : S_YIELD;
      default:  st_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      polls     <= '0;
      addr_q    <= '0;
      data_q    <= '0;
      last_q    <= 1'b0;
      done      <= 1'b0;
      timeout   <= 1'b0;
      req_ready <= 1'b1;
      mem_cs_n  <= 1'b1;
      mem_we_n  <= 1'b1;
      mem_oe_n  <= 1'b1;
      mem_dq_oe <= 1'b0;
    end else begin
      st  <= st_n;
      cnt <= (st_n != st) ? '0 : cnt + 1'b1;
      if (take) begin
        addr_q <= req_addr;
        data_q <= req_data;
        last_q <= req_last;
      end
      if (st == S_HOLD && st_n == S_YIELD)
        polls <= '0;
      else if (st == S_READ && at_end)
        polls <= polls + 1'b1;
      done      <= (st == S_READ) && at_end && match;
      timeout   <= (st == S_READ) && at_end && !match && last_poll;
      req_ready <= (st_n == S_IDLE) || (st_n == S_PAGE);
      mem_cs_n  <= !((st_n == S_SETUP) || (st_n == S_STROBE) ||
                     (st_n == S_HOLD)  || (st_n == S_READ));
      mem_we_n  <= (st_n != S_STROBE);
      mem_oe_n  <= (st_n != S_READ);
      mem_dq_oe <= (st_n == S_SETUP) || (st_n == S_STROBE) || (st_n == S_HOLD);
    end
  end

endmodule

// File: rtl/eeprom_poll_writer_chk.sv
module eeprom_poll_writer_chk #(
  parameter int AW      = 15,
  parameter int PULSE_C = 38,
  parameter int HIGH_C  = 13,
  parameter int YIELD_C = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          done,
  input logic          timeout,
  input logic [AW-1:0] mem_addr,
  input logic [7:0]    mem_dout,
  input logic          mem_dq_oe,
  input logic          mem_cs_n,
  input logic          mem_we_n,
  input logic          mem_oe_n
);
  logic [15:0]   lo_cnt, hi_cnt, csh_cnt;
  logic          we_prev, oe_prev, seen_load;
  logic [AW-1:0] ref_addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_cnt <= '0; hi_cnt <= '0; csh_cnt <= '0;
      we_prev <= 1'b1; oe_prev <= 1'b1; seen_load <= 1'b0; ref_addr <= '0;
    end else begin
      we_prev <= mem_we_n;
      oe_prev <= mem_oe_n;
      lo_cnt  <= mem_we_n ? '0 : lo_cnt + 1'b1;
      hi_cnt  <= !mem_we_n ? '0 : (hi_cnt == 16'hFFFF ? hi_cnt : hi_cnt + 1'b1);
      csh_cnt <= !mem_cs_n ? '0 : (csh_cnt == 16'hFFFF ? csh_cnt : csh_cnt + 1'b1);
      if (we_prev && !mem_we_n) begin
        seen_load <= 1'b1;
        ref_addr  <= mem_addr;
      end
    end
  end

  AST_STROBE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we_n && !we_prev) |-> (lo_cnt >= 16'(PULSE_C))); // R3
  AST_STROBE_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_dq_oe); // R3
  AST_DATA_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n && !we_prev) |-> $stable(mem_dout)); // R3
  AST_RECOVERY: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n && we_prev && seen_load) |-> (hi_cnt >= 16'(HIGH_C))); // R4
  AST_OE_VS_WE: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_oe_n && !mem_we_n)); // R5
  AST_OE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> !mem_dq_oe); // R5
  AST_YIELD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_oe_n && oe_prev) |-> (csh_cnt >= 16'(YIELD_C))); // R6
  AST_POLL_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (!mem_cs_n && mem_addr == ref_addr)); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_TIMEOUT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |=> !timeout); // R9
  AST_END_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && timeout)); // R12
  AST_READY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_we_n && mem_oe_n)); // R2
endmodule

bind eeprom_poll_writer eeprom_poll_writer_chk #(
  .AW(AW), .PULSE_C(PULSE_C), .HIGH_C(HIGH_C), .YIELD_C(YIELD_C)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .done(done), .timeout(timeout),
  .mem_addr(mem_addr), .mem_dout(mem_dout), .mem_dq_oe(mem_dq_oe),
  .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n)
);

// File: tb/eeprom_poll_writer_bench.sv
module eeprom_poll_writer_bench;
  localparam int AW = 15, CLK_NS = 4, YIELD = 64, WC = 40_000;

  function automatic int ceil_c(input int ns);
    return (ns + CLK_NS - 1) / CLK_NS;
  endfunction
  function automatic int exp_max_polls();
    return WC / (CLK_NS * (YIELD + ceil_c(150))) + 1;
  endfunction

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_ready, req_last = 0;
  logic [AW-1:0] req_addr = '0, mem_addr;
  logic [7:0] req_data = '0, mem_dout, mem_din;
  logic done, timeout, mem_dq_oe, mem_cs_n, mem_we_n, mem_oe_n;

  always #2 clk = ~clk;

  eeprom_poll_writer #(.AW(AW), .CLK_NS(CLK_NS), .YIELD_CYC(YIELD), .WC_NS(WC)) u_eeprom_poll_writer (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_data(req_data), .req_last(req_last),
    .done(done), .timeout(timeout), .mem_addr(mem_addr), .mem_dout(mem_dout),
    .mem_dq_oe(mem_dq_oe), .mem_din(mem_din), .mem_cs_n(mem_cs_n),
    .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n));

  // memory model with programmable busy time
  logic [7:0]  mem [256];
  logic [7:0]  last_d = '0;
  logic [31:0] busy_cnt = '0, prog_len = '0;
  logic        we_q = 1'b1, seen_busy = 1'b0, clr = 1'b0;
  wire         busy = (busy_cnt != 0);
  assign mem_din = (!mem_cs_n && !mem_oe_n) ?
                   (busy ? {~last_d[7], last_d[6:0]} : mem[mem_addr[7:0]]) : 8'h00;

  always @(posedge clk) begin
    we_q <= mem_we_n;
    if (mem_we_n && !we_q && !mem_cs_n && mem_dq_oe) begin
      mem[mem_addr[7:0]] <= mem_dout;
      last_d   <= mem_dout;
      busy_cnt <= prog_len;
    end else if (clr) busy_cnt <= '0;
    else if (busy) busy_cnt <= busy_cnt - 1;
    if (!mem_oe_n) seen_busy <= busy;
  end

  // bus monitors, sampled on the falling edge
  int polls_t = 0, busy_polls_t = 0, v_r3 = 0, v_r4 = 0, v_r5 = 0, v_r6 = 0, v_r7 = 0, v_r11 = 0;
  int lo_run = 0, hi_run = 0, cs_hi = 0, loads_in_op = 0;
  logic we_m = 1, oe_m = 1;
  logic [AW-1:0] strobe_addr = '0;
  logic [AW-1:0] cur_addr = '0;
  logic [7:0]    cur_data = '0;

  always @(negedge clk) begin
    if (!mem_we_n) begin
      lo_run++;
      if (!mem_dq_oe || mem_dout != cur_data) v_r3++;
      if (we_m) begin
        if (loads_in_op > 0 && hi_run < ceil_c(50)) v_r4++;
        strobe_addr = mem_addr;
      end
      hi_run = 0;
    end else begin
      if (!we_m) begin
        if (lo_run < ceil_c(150)) v_r3++;
        if (mem_dout != cur_data || mem_addr != cur_addr) v_r11++;
        loads_in_op++;
      end
      lo_run = 0;
      hi_run++;
    end
    if (!mem_oe_n && (!mem_we_n || mem_dq_oe)) v_r5++;
    if (!mem_oe_n && oe_m) begin
      if (cs_hi < YIELD) v_r6++;
      if (mem_addr != strobe_addr || mem_cs_n) v_r7++;
    end
    if (mem_oe_n && !oe_m) begin
      polls_t++;
      if (seen_busy) busy_polls_t++;
    end
    if (mem_cs_n) cs_hi++; else cs_hi = 0;
    if (mem_cs_n && mem_dq_oe) v_r6++;
    we_m = mem_we_n;
    oe_m = mem_oe_n;
  end

  int checks = 0, errors = 0, cycles = 0;
  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected below 190000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send(input logic [AW-1:0] a, input logic [7:0] d, input bit last);
    int guard = 0;
    @(negedge clk);
    while (!req_ready && guard < 5000) begin @(negedge clk); guard++; end
    cur_addr = a; cur_data = d;
    req_valid = 1; req_addr = a; req_data = d; req_last = last;
    @(negedge clk);
    req_valid = 0;
    chk(req_ready == 0, "R2", req_ready, 0);
  endtask

  logic [7:0] pd [8];
  logic [AW-1:0] pa [8];

  task automatic run_op(input logic [AW-1:0] base, input int n, input int plen,
                        input bit exp_to, input logic [7:0] first_d, input bit use_first);
    int p0, b0, s3, s4, s5, s6, s7, s11, guard;
    bit got_done, got_to;
    prog_len = plen;
    @(negedge clk); clr = 1; @(negedge clk); clr = 0;
    p0 = polls_t; b0 = busy_polls_t; s3 = v_r3; s4 = v_r4; s5 = v_r5;
    s6 = v_r6; s7 = v_r7; s11 = v_r11;
    loads_in_op = 0;
    for (int i = 0; i < n; i++) begin
      pa[i] = base + AW'(i);
      pd[i] = (i == 0 && use_first) ? first_d : 8'($urandom);
      if (i == n - 1 && n > 1) begin
        pd[i][7] = ~pd[0][7];
        chk(polls_t == p0, "R10 no poll before last byte", polls_t - p0, 0);
      end
      send(pa[i], pd[i], i == n - 1);
    end
    got_done = 0; got_to = 0; guard = 0;
    while (!done && !timeout && guard < 60000) begin @(negedge clk); guard++; end
    got_done = done; got_to = timeout;
    @(negedge clk);
    chk(done == 0 && timeout == 0, "R8 single-cycle end pulse", done | timeout, 0);
    chk(req_ready == 1, "R8 ready after end", req_ready, 1);
    if (exp_to) begin
      chk(got_to && !got_done, "R9 timeout raised", got_to, 1);
      chk(polls_t - p0 == exp_max_polls(), "R9 poll count", polls_t - p0, exp_max_polls());
    end else begin
      chk(got_done && !got_to, "R8 done raised", got_done, 1);
      chk(busy_polls_t - b0 == polls_t - p0 - 1, "R8 only final poll saw ready device",
          busy_polls_t - b0, polls_t - p0 - 1);
      if (plen == 0) chk(polls_t - p0 == 1, "R8 ready device needs one poll", polls_t - p0, 1);
    end
    for (int i = 0; i < n; i++)
      chk(mem[pa[i][7:0]] == pd[i], "R11 stored byte", mem[pa[i][7:0]], pd[i]);
    chk(v_r3 == s3, "R3 strobe width and data", v_r3 - s3, 0);
    chk(v_r4 == s4, "R4 strobe recovery", v_r4 - s4, 0);
    chk(v_r5 == s5, "R5 enable exclusion", v_r5 - s5, 0);
    chk(v_r6 == s6, "R6 yield gap", v_r6 - s6, 0);
    chk(v_r7 == s7, "R7 poll address", v_r7 - s7, 0);
    chk(v_r11 == s11, "R11 address and data at strobe end", v_r11 - s11, 0);
    chk(loads_in_op == n, "R10 strobes per operation", loads_in_op, n);
  endtask

  initial begin
    int seed;
    seed = $urandom(32'h5EED_0042);
    repeat (4) @(negedge clk);
    chk(req_ready == 1 && mem_cs_n && mem_we_n && mem_oe_n && !mem_dq_oe && !done && !timeout,
        "R1 reset state", {req_ready, mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe, done, timeout}, 7'b1111000);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready == 1 && mem_we_n && mem_oe_n, "R1 idle after reset", req_ready, 1);
    run_op(15'h0010, 1, 0, 0, 8'h80, 1);
    run_op(15'h0020, 1, 0, 0, 8'h00, 1);
    run_op(15'h0030, 1, 1, 0, 8'h7F, 1);
    for (int t = 0; t < 8; t++)
      run_op(AW'($urandom_range(0, 255)), 1, $urandom_range(1, 3000), 0, 8'h00, 0);
    run_op(15'h0040, 4, 1500, 0, 8'h11, 1);
    run_op(15'h0080, 2, 700, 0, 8'h90, 1);
    run_op(15'h00C0, 1, 32'h7FFF_FFFF, 1, 8'hA5, 1);
    run_op(15'h00D0, 1, 400, 0, 8'h3C, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule